// File: doc/BRIEF.md
# DDR Converter Word Rebuilder

This block takes a 10-bit converter sample that arrives on five data lanes at double data rate and turns it back into one parallel word. A forwarded output clock travels with the lanes. The system clock samples that clock and uses it as a phase indicator. In the low phase each lane carries one odd-numbered bit of the sample. In the high phase the same lane carries the even-numbered bit just below it. The block keeps the low-phase half until the matching high phase arrives. It then merges the two halves into a word and registers that word together with the converter's over-range flag. A single-cycle valid strobe marks each rebuilt sample.

A source-active enable input marks when the transmitter is driving its pins. When the source enters a power-saving state its outputs float. The enable is then deasserted, no word is produced, and any half-built word is thrown away. The sampled phase indicator must hold each level for at least one system clock cycle. The block treats a level that lasts several cycles as a single phase.

Top module: `ddr_word_rebuild`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, valid_o, word_o and ovr_o are all zero.
- R2: The lane_i[k] value sampled on the last low-phase cycle before a completed word appears as word_o bit 2k+1, for k from 0 to 4.
- R3: The lane_i[k] value sampled on the high-phase cycle that completes a word appears as word_o bit 2k, for k from 0 to 4.
- R4: A word is completed on the first system clock edge that samples fclk_i high after at least one enabled low-phase sample. On the next cycle valid_o is 1 for exactly one cycle, and word_o and ovr_o show the new sample.
- R5: ovr_o takes the ovr_i value sampled on the completing high-phase cycle. ovr_i values seen during the low phase have no effect.
- R6: A high phase that lasts several cycles gives only one valid pulse. A high phase not preceded by an enabled low phase since the last word, including one seen right after reset, gives none. valid_o is never high on two consecutive cycles.
- R7: While src_en_i is 0, valid_o stays 0 from the next cycle on, and any latched low half is discarded. After the enable returns, a high phase with no new low phase produces no valid pulse.
- R8: When the low phase lasts several cycles, the low-half bits are taken from the last low-phase cycle.
- R9: Between valid pulses, word_o and ovr_o keep the values of the last rebuilt sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_i | input | 5 | DDR data lanes |
| fclk_i | input | 1 | Forwarded clock level sampled in the system domain (0 = odd-bit phase, 1 = even-bit phase) |
| ovr_i | input | 1 | Over-range flag from the converter |
| src_en_i | input | 1 | 1 while the source is active and driving its outputs |
| word_o | output | 10 | Rebuilt sample |
| ovr_o | output | 1 | Over-range flag belonging to word_o |
| valid_o | output | 1 | One-cycle strobe for each new word |

## Verification
The assertions check on every cycle the properties that do not depend on data values:
- a completion always follows an enabled low-phase sample;
- valid never fires twice in a row;
- valid stays low while the source is off;
- the outputs hold still between strobes;
- the odd bits of each word equal the latched low half.

Only the bench scenarios can show that each lane's bit pair lands in the correct word positions. The same holds for:
- taking the flag from the high phase rather than the low phase;
- using the last of several low cycles;
- discarding a half word across an enable drop.

The bench shows these by comparing random and tabled words, in order, against its own split of each word.

// File: rtl/ddr_rb_pkg.sv
package ddr_rb_pkg;

  localparam int unsigned LANE_N = 5;
  localparam int unsigned WORD_N = 2 * LANE_N;

  typedef enum logic [0:0] {
    PH_WAIT_LOW = 1'b0,
    PH_HAVE_LOW = 1'b1
  } phase_state_e;

  // Bit pair for one lane: the odd bit (low phase) sits above the even bit.
  function automatic logic [1:0] pair_bits(input logic lo_bit, input logic hi_bit);
    return {lo_bit, hi_bit};
  endfunction

  // Odd-bit position carried by a lane during the low phase.
  function automatic int unsigned odd_pos(input int unsigned lane);
    return 2 * lane + 1;
  endfunction

  // Even-bit position carried by a lane during the high phase.
  function automatic int unsigned even_pos(input int unsigned lane);
    return 2 * lane;
  endfunction

endpackage

// File: rtl/rb_phase_tracker.sv
module rb_phase_tracker
  import ddr_rb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fclk_i,
  input  logic en_i,
  output logic low_cap_o,
  output logic complete_o
);

  phase_state_e state_q;
  phase_state_e state_d;

  // Named events for the other pieces and the assertions.
  logic low_seen_w;
  logic high_seen_w;

  assign low_seen_w  = en_i && !fclk_i;
  assign high_seen_w = en_i &&  fclk_i;

  assign low_cap_o  = low_seen_w;
  assign complete_o = high_seen_w && (state_q == PH_HAVE_LOW);

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = PH_WAIT_LOW;
    end else if (low_seen_w) begin
      state_d = PH_HAVE_LOW;
    end else if (complete_o) begin
      state_d = PH_WAIT_LOW;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PH_WAIT_LOW;
    end else begin
      state_q <= state_d;
    end
  end

  AST_COMPLETE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |-> $past(low_cap_o)); // R4

endmodule

// File: rtl/rb_half_capture.sv
module rb_half_capture #(
  parameter int unsigned LANES = ddr_rb_pkg::LANE_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             low_cap_i,
  input  logic [LANES-1:0] lane_i,
  output logic [LANES-1:0] lo_half_o
);

  logic [LANES-1:0] lo_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[k] <= 1'b0;
      end else if (!en_i) begin
        lo_q[k] <= 1'b0;
      end else if (low_cap_i) begin
        lo_q[k] <= lane_i[k];
      end
    end
  end

  assign lo_half_o = lo_q;

  AST_HALF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !low_cap_i) |=> $stable(lo_half_o)); // R8

endmodule

// File: rtl/rb_word_assembler.sv
module rb_word_assembler
  import ddr_rb_pkg::*;
#(
  parameter int unsigned LANES  = ddr_rb_pkg::LANE_N,
  localparam int unsigned WORDW = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             complete_i,
  input  logic [LANES-1:0] lo_half_i,
  input  logic [LANES-1:0] lane_i,
  input  logic             ovr_i,
  output logic [WORDW-1:0] word_o,
  output logic             ovr_o,
  output logic             valid_o
);

  logic [WORDW-1:0] merged_w;
  logic [LANES-1:0] odd_view_w;
  logic [WORDW-1:0] word_q;
  logic             ovr_q;
  logic             valid_q;

  for (genvar k = 0; k < LANES; k++) begin : g_merge
    assign merged_w[odd_pos(k):even_pos(k)] = pair_bits(lo_half_i[k], lane_i[k]);
    assign odd_view_w[k] = word_q[odd_pos(k)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      ovr_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= en_i && complete_i;
      if (en_i && complete_i) begin
        word_q <= merged_w;
        ovr_q  <= ovr_i;
      end
    end
  end

  assign word_o  = word_q;
  assign ovr_o   = ovr_q;
  assign valid_o = valid_q;

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R6
  AST_OFF_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !valid_o); // R7
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(word_o) && $stable(ovr_o))); // R9
  AST_ODD_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && complete_i) |=> (odd_view_w == $past(lo_half_i))); // R2

endmodule

// File: rtl/ddr_word_rebuild.sv
module ddr_word_rebuild #(
  parameter int unsigned LANES  = ddr_rb_pkg::LANE_N,
  localparam int unsigned WORDW = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_i,
  input  logic             fclk_i,
  input  logic             ovr_i,
  input  logic             src_en_i,
  output logic [WORDW-1:0] word_o,
  output logic             ovr_o,
  output logic             valid_o
);

  logic             low_cap_w;
  logic             complete_w;
  logic [LANES-1:0] lo_half_w;

  rb_phase_tracker u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .fclk_i     (fclk_i),
    .en_i       (src_en_i),
    .low_cap_o  (low_cap_w),
    .complete_o (complete_w)
  );

  rb_half_capture #(.LANES(LANES)) u_half (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (src_en_i),
    .low_cap_i (low_cap_w),
    .lane_i    (lane_i),
    .lo_half_o (lo_half_w)
  );

  rb_word_assembler #(.LANES(LANES)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (src_en_i),
    .complete_i (complete_w),
    .lo_half_i  (lo_half_w),
    .lane_i     (lane_i),
    .ovr_i      (ovr_i),
    .word_o     (word_o),
    .ovr_o      (ovr_o),
    .valid_o    (valid_o)
  );

  AST_VALID_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(fclk_i) && $past(src_en_i))); // R4

endmodule

// File: tb/ddr_word_rebuild_tb_top.sv
`timescale 1ns/1ps
module ddr_word_rebuild_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] lane_i = '0;
  logic       fclk_i = 1'b0;
  logic       ovr_i = 1'b0;
  logic       src_en_i = 1'b0;
  logic [9:0] word_o;
  logic       ovr_o;
  logic       valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ddr_word_rebuild dut_i (
    .clk(clk), .rst_n(rst_n), .lane_i(lane_i), .fclk_i(fclk_i),
    .ovr_i(ovr_i), .src_en_i(src_en_i),
    .word_o(word_o), .ovr_o(ovr_o), .valid_o(valid_o)
  );

  // {ovr, word}
  localparam logic [10:0] VEC [16] = '{
    11'h000, 11'h3FF, 11'h7FF, 11'h2AA, 11'h155, 11'h401, 11'h200, 11'h523,
    11'h0F0, 11'h70F, 11'h3C3, 11'h081, 11'h612, 11'h399, 11'h4AB, 11'h1E7
  };

  function automatic logic [4:0] odd_lanes(input logic [9:0] w);
    logic [4:0] r;
    for (int k = 0; k < 5; k++) r[k] = w[2*k+1];
    return r;
  endfunction

  function automatic logic [4:0] even_lanes(input logic [9:0] w);
    logic [4:0] r;
    for (int k = 0; k < 5; k++) r[k] = w[2*k];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a negedge, then wait for the next negedge (one posedge in between).
  task automatic step(input logic f, input logic [4:0] l, input logic ov);
    fclk_i = f; lane_i = l; ovr_i = ov;
    @(negedge clk);
  endtask

  task automatic send(input logic [9:0] w, input logic ov, input int nlow, input int nhigh,
                      input string req);
    for (int i = 0; i < nlow; i++) begin
      // Early low cycles carry decoy bits; only the last one counts (R8).
      step(1'b0, (i == nlow-1) ? odd_lanes(w) : ~odd_lanes(w), ~ov);
    end
    for (int j = 0; j < nhigh; j++) begin
      step(1'b1, even_lanes(w), ov);
      if (j == 0) begin
        check(valid_o == 1'b1, {req, " R4 valid"}, valid_o, 1);
        check(word_o == w, {req, " R2 R3 word"}, word_o, w);
        check(ovr_o == ov, {req, " R5 ovr"}, ovr_o, ov);
      end else begin
        check(valid_o == 1'b0, {req, " R6 long high"}, valid_o, 0);
        check(word_o == w, {req, " R9 hold"}, word_o, w);
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [9:0] last_w;
    logic       last_o;
    @(negedge clk);
    @(negedge clk);
    check(valid_o == 0 && word_o == 0 && ovr_o == 0, "R1 in reset",
          {valid_o, ovr_o, word_o}, 0);
    src_en_i = 1'b1;
    fclk_i = 1'b1;
    lane_i = 5'h1F;
    ovr_i = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o == 0 && word_o == 0 && ovr_o == 0, "R1 R6 after reset high",
          {valid_o, ovr_o, word_o}, 0);
    step(1'b1, 5'h1F, 1'b1);
    check(valid_o == 0, "R6 high without low", valid_o, 0);

    // Table walk with varied phase lengths.
    for (int i = 0; i < 16; i++) begin
      send(VEC[i][9:0], VEC[i][10], 1 + (i % 3), 1 + (i % 2), "table");
    end

    // Enable drop discards the half word.
    step(1'b0, odd_lanes(10'h3FF), 1'b0);
    src_en_i = 1'b0;
    step(1'b1, even_lanes(10'h3FF), 1'b1);
    check(valid_o == 0, "R7 off high", valid_o, 0);
    step(1'b0, 5'h1F, 1'b1);
    check(valid_o == 0, "R7 off low", valid_o, 0);
    step(1'b1, 5'h1F, 1'b1);
    check(valid_o == 0, "R7 off high again", valid_o, 0);
    src_en_i = 1'b1;
    step(1'b1, 5'h1F, 1'b1);
    check(valid_o == 0, "R7 re-enable high no low", valid_o, 0);
    check(word_o == VEC[15][9:0], "R9 held over off", word_o, VEC[15][9:0]);
    send(10'h2C5, 1'b1, 1, 1, "after R7");

    // Idle stretch in the high phase keeps the last word.
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 5'h0A, 1'b0);
      check(valid_o == 0 && word_o == 10'h2C5 && ovr_o == 1'b1, "R9 idle",
            {valid_o, ovr_o, word_o}, {2'b01, 10'h2C5});
    end

    // Random words in order.
    for (int i = 0; i < 60; i++) begin
      last_w = 10'($urandom);
      last_o = 1'($urandom);
      send(last_w, last_o, 1 + int'($urandom % 3), 1 + int'($urandom % 3), "random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule